// File: doc/BRIEF.md
# Thermal threshold interrupt unit

This unit watches 8-bit raw temperature codes that a sensor front end delivers with a one-cycle valid strobe. Software stores three rising alarm set points (throttle, warning, trip) and one falling set point, given in degrees Celsius. At write time the unit turns each set point into a sensor code, using a trim input and a fixed bias. Each valid sample is compared against the four codes. A crossing latches a pending bit for that level. A single interrupt line is driven whenever a pending bit is set and its enable bit is also set.

A pending bit is an edge event, not a level. A rising level fires once, on the first sample that reaches its code. It fires again only after a sample has fallen below that code. The falling level behaves the same way in the opposite direction. Software clears pending bits through a write-only clear location. It reads back the last sample, the raw pending bits and the identity of the highest-priority enabled event. The unit is meant to sit behind a thin register-bus adapter. The interrupt handler reads the status word, serves the reported level and clears that level alone.

Top module: `thermal_alarm_unit`

## Requirements
- R1: After reset the rising word (address 0) reads 0xFFFFFFFF, the falling word (address 1) reads 0, the enable word (address 2) reads 0, the status word (address 3) reads 0, and irq is low.
- R2: A write to address 0 takes Celsius set points from bits [7:0] (level 0), [15:8] (level 1) and [23:16] (level 2). Each is stored as the code C + trim - CELSIUS_BIAS. The word reads back with the stored codes in the same lanes and 0xFF in bits [31:24], whatever was written there.
- R3: If trim_in is zero, TRIM_FALLBACK (default 0x37) is used in its place. A converted code below 0 is stored as 0x00 and one above 255 as 0xFF. Address 1 takes its Celsius value from bits [7:0].
- R4: A rising level's pending bit sets at the clock edge that samples code_vld high with code_in greater than or equal to that level's code.
- R5: After a rising level has fired, it does not fire again until a valid sample below its code has been seen.
- R6: The falling pending bit sets on a valid sample with code_in less than or equal to the falling code. It re-arms only after a valid sample above that code.
- R7: A write to address 3 clears pending bits. Bit 0 clears level 0, bit 1 level 1, bit 2 level 2 and bit 3 the falling level; a write with bit 31 set clears all four.
- R8: When a clear and a new set reach the same pending bit in the same cycle, the bit ends up set.
- R9: Address 2 bits [3:0] enable the four levels in the order of R7. irq is high exactly when some pending bit and its enable are both set. Pending bits are recorded whether or not they are enabled.
- R10: Status bits [18:16] name the highest-priority pending and enabled event: 4 for falling, then 3 for level 2, 2 for level 1, 1 for level 0, and 0 for none. Bits [11:8] hold the raw pending bits in the order of R7.
- R11: Status bits [7:0] hold the code of the last valid sample. A code_in value presented without code_vld leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_in | input | 8 | Raw temperature code from the sensor front end |
| code_vld | input | 1 | One-cycle strobe marking code_in as a new sample |
| trim_in | input | 8 | Sensor trim value; zero selects the fallback |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address (combinational read) |
| rd_data | output | 32 | Register read data |
| irq | output | 1 | Combined interrupt |

## Verification
The arming flags are the one piece of hidden state. A wrong arming flag shows up at the ports one sample later: either a level that fires again while the temperature stays above its code, or a level that stays silent after the temperature has come back down and crossed again. For that reason the bench clears levels and then keeps the code above or below the threshold, and reads the status after every sample. A wrong conversion or lane placement shows up at the very next read of the threshold words. A wrong priority or gating shows up in the same cycle as the pending change, in the status identity field and in irq.

// File: rtl/thermal_alarm_pkg.sv
// Package: shared widths, register addresses and the Celsius-to-code
// conversion used by the configuration registers.
package thermal_alarm_pkg;
    localparam int CODE_W = 8;            // sensor code width
    localparam int N_RISE = 3;            // rising levels packed in one word
    localparam int N_LVL  = N_RISE + 1;   // plus the falling level
    localparam int ID_W   = 3;            // width of the priority identity

    localparam logic [1:0] ADDR_RISE = 2'd0;
    localparam logic [1:0] ADDR_FALL = 2'd1;
    localparam logic [1:0] ADDR_EN   = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;  // read: status, write: clear

    // Convert a Celsius set point to a sensor code, clamped to 0..255.
    function automatic logic [CODE_W-1:0] celsius_to_code(
        input logic [CODE_W-1:0] celsius,
        input logic [CODE_W-1:0] trim,
        input logic [CODE_W-1:0] bias
    );
        logic signed [CODE_W+2:0] sum;
        sum = $signed({3'b000, celsius}) + $signed({3'b000, trim})
            - $signed({3'b000, bias});
        if (sum < 0)
            return '0;
        else if (sum > 11'sd255)
            return '1;
        else
            return sum[CODE_W-1:0];
    endfunction
endpackage

// File: rtl/thermal_alarm_cfg.sv
// Configuration registers: stores converted threshold codes and enables.
// It decodes the clear location into a one-cycle clear mask. Assumes the
// trim input is stable whenever a threshold is written.
module thermal_alarm_cfg
    import thermal_alarm_pkg::*;
#(
    parameter logic [CODE_W-1:0] BIAS     = 8'd25,
    parameter logic [CODE_W-1:0] FALLBACK = 8'h37
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [CODE_W-1:0]              trim_in,
    input  logic                           wr_en,
    input  logic [1:0]                     wr_addr,
    input  logic [31:0]                    wr_data,
    output logic [N_RISE-1:0][CODE_W-1:0]  rise_thr,
    output logic [CODE_W-1:0]              fall_thr,
    output logic [N_LVL-1:0]               lvl_en,
    output logic [N_LVL-1:0]               clr
);
    logic [CODE_W-1:0] trim_eff;
    logic              unused_bits;

    // Substitute the fallback trim for an unprogrammed (zero) trim.
    always_comb trim_eff = (trim_in == '0) ? FALLBACK : trim_in;

    // Bits no register decodes.
    always_comb unused_bits = ^wr_data[30:24];

    // Threshold and enable storage, converted on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_thr <= '1;
            fall_thr <= '0;
            lvl_en   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_RISE: for (int i = 0; i < N_RISE; i++)
                    rise_thr[i] <= celsius_to_code(wr_data[CODE_W*i +: CODE_W], trim_eff, BIAS);
                ADDR_FALL: fall_thr <= celsius_to_code(wr_data[CODE_W-1:0], trim_eff, BIAS);
                ADDR_EN:   lvl_en   <= wr_data[N_LVL-1:0];
                default:   ;
            endcase
        end
    end

    // Clear mask: per-level bits, or every level when bit 31 is set.
    always_comb begin
        clr = '0;
        if (wr_en && wr_addr == ADDR_STAT)
            clr = wr_data[31] ? '1 : wr_data[N_LVL-1:0];
    end
endmodule

// File: rtl/thermal_alarm_level.sv
// One threshold detector: latches a pending bit on a crossing sample and
// stays disarmed until a sample on the other side of the threshold.
// FALLING selects "at or below" in place of "at or above".
module thermal_alarm_level
    import thermal_alarm_pkg::*;
#(
    parameter bit FALLING = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] smp_code,
    input  logic [CODE_W-1:0] thr,
    input  logic              clr,
    output logic              pend
);
    logic armed;
    logic beyond;
    logic fire;

    // Which side of the threshold the sample lies on.
    generate
        if (FALLING) begin : g_fall
            always_comb beyond = (smp_code <= thr);
        end else begin : g_rise
            always_comb beyond = (smp_code >= thr);
        end
    endgenerate

    // A crossing counts only while armed.
    always_comb fire = smp_vld && beyond && armed;

    // Arming follows each valid sample; a set beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
            pend  <= 1'b0;
        end else begin
            if (smp_vld)
                armed <= !beyond;
            pend <= fire || (pend && !clr);
        end
    end
endmodule

// File: rtl/thermal_alarm_prio.sv
// Priority encoder: reports the most urgent enabled pending event
// (falling, then level 2, 1, 0) and drives the combined interrupt.
module thermal_alarm_prio
    import thermal_alarm_pkg::*;
(
    input  logic [N_LVL-1:0] pend,
    input  logic [N_LVL-1:0] lvl_en,
    output logic [ID_W-1:0]  top_id,
    output logic             irq
);
    logic [N_LVL-1:0] live;

    // Pick the identity of the highest-priority live event.
    always_comb begin
        live   = pend & lvl_en;
        irq    = |live;
        top_id = '0;
        for (int i = 0; i < N_LVL; i++)
            if (live[i])
                top_id = ID_W'(i + 1);
    end
endmodule

// File: rtl/thermal_alarm_unit.sv
// Top: threshold interrupt unit. Holds the last valid sample, instantiates
// the configuration block, one detector per level and the priority
// encoder, and serves a combinational register read.
module thermal_alarm_unit
    import thermal_alarm_pkg::*;
#(
    parameter int          CELSIUS_BIAS  = 25,
    parameter logic [7:0]  TRIM_FALLBACK = 8'h37
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  code_in,
    input  logic        code_vld,
    input  logic [7:0]  trim_in,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        irq
);
    logic [N_RISE-1:0][CODE_W-1:0] rise_thr;
    logic [CODE_W-1:0]             fall_thr;
    logic [N_LVL-1:0]              lvl_en;
    logic [N_LVL-1:0]              clr;
    logic [N_LVL-1:0]              pend;
    logic [ID_W-1:0]               top_id;
    logic [CODE_W-1:0]             cur_code;

    thermal_alarm_cfg #(
        .BIAS     (CODE_W'(CELSIUS_BIAS)),
        .FALLBACK (TRIM_FALLBACK)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .trim_in  (trim_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rise_thr (rise_thr),
        .fall_thr (fall_thr),
        .lvl_en   (lvl_en),
        .clr      (clr)
    );

    generate
        for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
            if (g < N_RISE) begin : g_r
                thermal_alarm_level #(.FALLING(1'b0)) u_det (
                    .clk(clk), .rst_n(rst_n), .smp_vld(code_vld),
                    .smp_code(code_in), .thr(rise_thr[g]),
                    .clr(clr[g]), .pend(pend[g])
                );
            end else begin : g_f
                thermal_alarm_level #(.FALLING(1'b1)) u_det (
                    .clk(clk), .rst_n(rst_n), .smp_vld(code_vld),
                    .smp_code(code_in), .thr(fall_thr),
                    .clr(clr[g]), .pend(pend[g])
                );
            end
        end
    endgenerate

    thermal_alarm_prio u_prio (
        .pend   (pend),
        .lvl_en (lvl_en),
        .top_id (top_id),
        .irq    (irq)
    );

    // Capture the code of each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_code <= '0;
        else if (code_vld)
            cur_code <= code_in;
    end

    // Register read multiplexer.
    always_comb begin
        case (rd_addr)
            ADDR_RISE: rd_data = {8'hFF, rise_thr[2], rise_thr[1], rise_thr[0]};
            ADDR_FALL: rd_data = {24'd0, fall_thr};
            ADDR_EN:   rd_data = {28'd0, lvl_en};
            default:   rd_data = {13'd0, top_id, 4'd0, pend, cur_code};
        endcase
    end
endmodule

// File: rtl/thermal_alarm_unit_chk.sv
// Checker for thermal_alarm_unit: relates pending-bit changes to the
// samples and writes that caused them. Attached by bind below.
module thermal_alarm_unit_chk (
    input logic             clk,
    input logic             rst_n,
    input logic             code_vld,
    input logic [7:0]       code_in,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic [2:0][7:0]  rise_thr,
    input logic [7:0]       fall_thr,
    input logic [3:0]       pend
);
    logic unused_chk;
    always_comb unused_chk = ^wr_data[30:4];

    generate
        for (genvar i = 0; i < 3; i++) begin : g_rise
            // R4: a rising pending bit only appears after a qualifying sample
            a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend[i]) |-> ($past(code_vld) && ($past(code_in) >= $past(rise_thr[i]))));
        end
        for (genvar j = 0; j < 4; j++) begin : g_clr
            // R7: a pending bit only drops after a clear write covering it
            a_r7_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pend[j]) |-> $past(wr_en && wr_addr == 2'd3 && (wr_data[31] || wr_data[j])));
        end
    endgenerate

    // R6: the falling pending bit only appears after a low enough sample
    a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[3]) |-> ($past(code_vld) && ($past(code_in) <= $past(fall_thr))));

    // R2: rising codes change only after a write to the rising word
    a_r2_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && wr_addr == 2'd0) |-> $stable(rise_thr));
endmodule

bind thermal_alarm_unit thermal_alarm_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_vld (code_vld),
    .code_in  (code_in),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rise_thr (rise_thr),
    .fall_thr (fall_thr),
    .pend     (pend)
);

// File: tb/test_thermal_alarm_unit.sv
// Scoreboard bench: read tasks queue expected items, a monitor at the
// falling edge pops and compares them against rd_data and irq.
module test_thermal_alarm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  code_in = '0;
    logic        code_vld = 1'b0;
    logic [7:0]  trim_in = 8'h40;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    typedef struct {
        string       tag;
        logic [31:0] data;
        logic        irq;
    } item_t;
    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    thermal_alarm_unit i_thermal_alarm_unit (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .code_vld(code_vld),
        .trim_in(trim_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // Independent model of the set point conversion (R2, R3).
    function automatic logic [7:0] exp_code(int c, int trim);
        int t = (trim == 0) ? 'h37 : trim;
        int s = c + t - 25;
        if (s < 0) return 8'h00;
        if (s > 255) return 8'hFF;
        return 8'(s);
    endfunction

    task automatic tick();
        @(posedge clk); #1;
        wr_en = 1'b0;
        code_vld = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic smp(input logic [7:0] c);
        code_vld = 1'b1; code_in = c;
        tick();
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [31:0] d,
                             input logic ei, input string tag);
        item_t it;
        rd_addr = a;
        it.tag = tag; it.data = d; it.irq = ei;
        q.push_back(it);
        tick();
    endtask

    // Monitor: compare queued expectations away from the active edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (rd_data !== it.data || irq !== it.irq) begin
                n_fail++;
                $display("FAIL %s: got rd_data=%h irq=%b, expected rd_data=%h irq=%b",
                         it.tag, rd_data, irq, it.data, it.irq);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        expect_rd(2'd3, 32'h0, 1'b0, "R1 status");
        expect_rd(2'd0, 32'hFFFF_FFFF, 1'b0, "R1 rising");
        expect_rd(2'd1, 32'h0, 1'b0, "R1 falling");
        expect_rd(2'd2, 32'h0, 1'b0, "R1 enable");
        // R2: conversion, lane placement, top byte ignored
        wr(2'd0, 32'h125A_5046);
        expect_rd(2'd0, {8'hFF, exp_code(90, 'h40), exp_code(80, 'h40), exp_code(70, 'h40)},
                  1'b0, "R2 rising word");
        // R3: fallback trim and clamp
        trim_in = 8'h00; wr(2'd1, 32'h1E);
        expect_rd(2'd1, {24'd0, exp_code(30, 0)}, 1'b0, "R3 fallback trim");
        trim_in = 8'h01; wr(2'd1, 32'h03);
        expect_rd(2'd1, 32'h0, 1'b0, "R3 clamp low");
        trim_in = 8'h40; wr(2'd1, 32'h28);
        expect_rd(2'd1, 32'h4F, 1'b0, "R3 falling code");
        wr(2'd2, 32'hF);
        expect_rd(2'd2, 32'hF, 1'b0, "R9 enable readback");
        // R4: no crossing, then exact equality
        smp(8'h60);
        expect_rd(2'd3, 32'h0000_0060, 1'b0, "R4 below threshold");
        smp(8'h6D);
        expect_rd(2'd3, 32'h0001_016D, 1'b1, "R4 equal fires");
        // R5: one-shot until re-armed
        smp(8'h70); wr(2'd3, 32'h1);
        expect_rd(2'd3, 32'h0000_0070, 1'b0, "R7 clear level 0");
        smp(8'h72);
        expect_rd(2'd3, 32'h0000_0072, 1'b0, "R5 no refire");
        smp(8'h60); smp(8'h6E);
        expect_rd(2'd3, 32'h0001_016E, 1'b1, "R5 refire after rearm");
        // R10: several rising levels
        smp(8'h81);
        expect_rd(2'd3, 32'h0003_0781, 1'b1, "R10 level 2 first");
        // R9: gating by enables
        wr(2'd2, 32'hB);
        expect_rd(2'd3, 32'h0002_0781, 1'b1, "R9 level 2 masked");
        wr(2'd2, 32'h0);
        expect_rd(2'd3, 32'h0000_0781, 1'b0, "R9 all masked");
        smp(8'h40);
        expect_rd(2'd3, 32'h0000_0F40, 1'b0, "R9 recorded while disabled");
        wr(2'd3, 32'h8000_0000);
        expect_rd(2'd3, 32'h0000_0040, 1'b0, "R7 clear all");
        wr(2'd2, 32'hF);
        // R6: falling one-shot and equality
        smp(8'h3F);
        expect_rd(2'd3, 32'h0000_003F, 1'b0, "R6 no refire");
        smp(8'h50); smp(8'h4F);
        expect_rd(2'd3, 32'h0004_084F, 1'b1, "R6 equal fires");
        smp(8'h82);
        expect_rd(2'd3, 32'h0004_0F82, 1'b1, "R10 falling first");
        wr(2'd3, 32'h8);
        expect_rd(2'd3, 32'h0003_0782, 1'b1, "R7 clear falling only");
        // R8: set beats clear in the same cycle
        wr(2'd3, 32'h8000_0000); smp(8'h50);
        code_vld = 1'b1; code_in = 8'h6D;
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'h1;
        tick();
        expect_rd(2'd3, 32'h0001_016D, 1'b1, "R8 set wins");
        // R11: code without strobe ignored
        code_in = 8'hAA; tick();
        expect_rd(2'd3, 32'h0001_016D, 1'b1, "R11 no strobe");
        tick();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule